// File: doc/BRIEF.md
# Row-Buffer Cached DRAM Bank Front End

This block sits in front of a multi-bank DRAM array and gives every bank a small SRAM copy of the row it opened most recently. Requests arrive one at a time on a valid/ready handshake. Each request carries a bank, row, column, write flag and write data. A read that targets the row held in the bank's copy is answered straight from that copy and does not touch the bank's sense amplifiers. Any other access goes through a modelled array path that holds the bank's sense amplifiers for precharge, activate and column access. The array itself is a small register model inside the block, and its latencies are set by parameters.

Writes always pass through the sense amplifiers. A write to the buffered row updates both the copy and the array. A write to any other row opens that row, merges the new word and keeps the row as the new copy. A periodic refresh takes the sense amplifiers of every bank at once. Reads of a buffered row keep flowing while the bank's amplifiers are held by a refresh, by a write or by an earlier array access. The block keeps only one request in flight, so responses leave in the order the requests were accepted. Counters of hits and misses are visible for verification.

Top module: `rbc_dram_fe`

## Requirements
- R1: After reset, req_ready_o is 1, rsp_valid_o is 0, sa_busy_o is all zero, both counters are 0 and no bank holds a buffered row.
- R2: A read accepted at a clock edge whose bank holds the requested row in its buffer drives rsp_valid_o with the buffered word in the cycle right after that edge. It does not set that bank's sa_busy_o bit.
- R3: A buffered-row read gets that same one-cycle response while the bank's sa_busy_o bit is set, whether a write or a refresh is holding it.
- R4: A read whose row is not buffered waits for the bank's sense amplifiers, then holds them for T_PRE+T_ACT+T_CAS cycles. It responds with the array word. With the bank idle and no refresh pending, rsp_valid_o rises T_PRE+T_ACT+T_CAS+1 cycles later than it would for a hit. The row then becomes the bank's buffered row.
- R5: A write to the buffered row stores the word in both the buffer and the array, and holds the bank's sa_busy_o bit for T_CAS cycles. Later hits return the new word.
- R6: Writes are serialised on the sense amplifiers. A write that finds its bank's sa_busy_o bit set waits, and req_ready_o stays 0 until the write has started.
- R7: Every REFRESH_INTERVAL cycles a refresh sets every sa_busy_o bit together for T_RFC cycles. If the block is idle, the refreshes start exactly REFRESH_INTERVAL cycles apart.
- R8: Reads produce exactly one response each, in acceptance order. Writes produce none.
- R9: Reads that alternate between two rows of one bank miss on every access, and each pays the full miss latency.
- R10: hit_count_o increases by one for each accepted request that finds its row buffered. miss_count_o increases by one for each other accepted request. At most one of the two changes per cycle.
- R11: A write to a row that is not buffered opens the row, merges the word into the buffered copy and the array, and makes that row the buffered row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be accepted |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_bank_i | input | $clog2(NUM_BANKS) | Bank index |
| req_row_i | input | $clog2(ROWS) | Row index |
| req_col_i | input | $clog2(COLS) | Column index |
| req_wdata_i | input | DATA_W | Write data |
| rsp_valid_o | output | 1 | Read data valid strobe |
| rsp_data_o | output | DATA_W | Read data |
| sa_busy_o | output | NUM_BANKS | Per-bank sense-amplifier busy |
| hit_count_o | output | CNT_W | Buffered-row access count |
| miss_count_o | output | CNT_W | Array-path access count |

## Verification
The hardest case to reach from the ports is a buffered-row read that lands inside the short window in which the same bank's sense amplifiers are held. That window lasts T_CAS cycles after a write, or T_RFC cycles during a refresh. The stimulus reaches the write window by issuing a read hit on the cycle right after a write to the same row. It reaches the refresh window by polling sa_busy_o until all bits rise together and then issuing the read at once. It confirms that the amplifiers are still busy just before the read is accepted. Miss latency is measured exactly only right after a refresh has ended, so that no pending refresh stretches it.

// File: rtl/rbc_pkg.sv
package rbc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_ARRAY = 2'd2
  } fe_state_e;
endpackage

// File: rtl/rbc_sa_tracker.sv
module rbc_sa_tracker #(
  parameter int NUM_BANKS = 4,
  parameter int LEN_W     = 4,
  parameter int T_RFC     = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_BANKS-1:0] start_i,
  input  logic [LEN_W-1:0]     len_i,
  input  logic                 rfr_i,
  output logic [NUM_BANKS-1:0] busy_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [LEN_W-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           cnt_q <= '0;
      else if (rfr_i)        cnt_q <= LEN_W'(T_RFC);
      else if (start_i[b])   cnt_q <= len_i;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end
    assign busy_o[b] = (cnt_q != '0);
  end
endmodule

// File: rtl/rbc_refresh_timer.sv
module rbc_refresh_timer #(
  parameter int INTERVAL = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  output logic pend_o
);
  localparam int IW = $clog2(INTERVAL + 1);
  logic [IW-1:0] cnt_q;
  logic          wrap;

  assign wrap = (cnt_q == IW'(INTERVAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_o <= 1'b0;
    end else begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      if (wrap)       pend_o <= 1'b1;
      else if (ack_i) pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rbc_row_store.sv
module rbc_row_store #(
  parameter int NUM_BANKS = 4,
  parameter int ROWS      = 8,
  parameter int COLS      = 4,
  parameter int DATA_W    = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [$clog2(NUM_BANKS)-1:0] bank_i,
  input  logic [$clog2(ROWS)-1:0]      row_i,
  input  logic [$clog2(COLS)-1:0]      col_i,
  input  logic [DATA_W-1:0]            wdata_i,
  input  logic                         wr_hit_i,
  input  logic                         fill_i,
  input  logic                         fill_wr_i,
  output logic                         hit_o,
  output logic [DATA_W-1:0]            buf_rdata_o,
  output logic [DATA_W-1:0]            arr_rdata_o
);
  localparam int RW = $clog2(ROWS);
  localparam int CW = $clog2(COLS);

  logic [DATA_W-1:0]    arr_q [NUM_BANKS][ROWS][COLS];
  logic [DATA_W-1:0]    buf_q [NUM_BANKS][COLS];
  logic [RW-1:0]        tag_q [NUM_BANKS];
  logic [NUM_BANKS-1:0] vld_q;

  assign hit_o       = vld_q[bank_i] && (tag_q[bank_i] == row_i);
  assign buf_rdata_o = buf_q[bank_i][col_i];
  assign arr_rdata_o = arr_q[bank_i][row_i][col_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
        tag_q[b] <= '0;
        for (int c = 0; c < COLS; c++) begin
          buf_q[b][c] <= '0;
          for (int r = 0; r < ROWS; r++) arr_q[b][r][c] <= '0;
        end
      end
    end else if (wr_hit_i) begin
      buf_q[bank_i][col_i]        <= wdata_i;
      arr_q[bank_i][row_i][col_i] <= wdata_i;
    end else if (fill_i) begin
      tag_q[bank_i] <= row_i;
      vld_q[bank_i] <= 1'b1;
      for (int c = 0; c < COLS; c++)
        buf_q[bank_i][c] <= (fill_wr_i && col_i == CW'(c)) ? wdata_i
                                                            : arr_q[bank_i][row_i][c];
      if (fill_wr_i) arr_q[bank_i][row_i][col_i] <= wdata_i;
    end
  end
endmodule

// File: rtl/rbc_dram_fe.sv
module rbc_dram_fe
  import rbc_pkg::*;
#(
  parameter int NUM_BANKS        = 4,
  parameter int ROWS             = 8,
  parameter int COLS             = 4,
  parameter int DATA_W           = 16,
  parameter int T_PRE            = 2,
  parameter int T_ACT            = 2,
  parameter int T_CAS            = 2,
  parameter int T_RFC            = 6,
  parameter int REFRESH_INTERVAL = 64,
  parameter int CNT_W            = 16,
  localparam int BW              = $clog2(NUM_BANKS),
  localparam int RW              = $clog2(ROWS),
  localparam int CW              = $clog2(COLS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic                 req_write_i,
  input  logic [BW-1:0]        req_bank_i,
  input  logic [RW-1:0]        req_row_i,
  input  logic [CW-1:0]        req_col_i,
  input  logic [DATA_W-1:0]    req_wdata_i,
  output logic                 rsp_valid_o,
  output logic [DATA_W-1:0]    rsp_data_o,
  output logic [NUM_BANKS-1:0] sa_busy_o,
  output logic [CNT_W-1:0]     hit_count_o,
  output logic [CNT_W-1:0]     miss_count_o
);
  localparam int T_MISS = T_PRE + T_ACT + T_CAS;
  localparam int LW     = $clog2(T_MISS + T_RFC + 1);

  fe_state_e state_q, state_d;
  logic [BW-1:0]     bank_q;
  logic [RW-1:0]     row_q;
  logic [CW-1:0]     col_q;
  logic [DATA_W-1:0] wdata_q;
  logic              wr_q;
  logic [LW-1:0]     arr_cnt_q, arr_cnt_d;

  logic [BW-1:0]     cur_bank;
  logic [RW-1:0]     cur_row;
  logic [CW-1:0]     cur_col;
  logic [DATA_W-1:0] cur_wdata;
  logic              idle, accept, can_sa;
  logic              lookup_hit, wr_hit, fill, rsp_fire, rsp_from_buf;
  logic [DATA_W-1:0] buf_rdata, arr_rdata;
  logic [NUM_BANKS-1:0] sa_start;
  logic [LW-1:0]     sa_len;
  logic              rfr_pend, rfr_start;

  assign idle        = (state_q == ST_IDLE);
  assign req_ready_o = idle;
  assign accept      = req_valid_i && idle;
  assign cur_bank    = idle ? req_bank_i  : bank_q;
  assign cur_row     = idle ? req_row_i   : row_q;
  assign cur_col     = idle ? req_col_i   : col_q;
  assign cur_wdata   = idle ? req_wdata_i : wdata_q;
  assign can_sa      = !sa_busy_o[cur_bank] && !rfr_pend;
  // refresh waits for every bank to drain; new array work waits for refresh
  assign rfr_start   = rfr_pend && !(|sa_busy_o) && (state_q != ST_ARRAY);

  rbc_row_store #(
    .NUM_BANKS(NUM_BANKS), .ROWS(ROWS), .COLS(COLS), .DATA_W(DATA_W)
  ) u_store (
    .clk_i, .rst_ni,
    .bank_i(cur_bank), .row_i(cur_row), .col_i(cur_col), .wdata_i(cur_wdata),
    .wr_hit_i(wr_hit), .fill_i(fill), .fill_wr_i(wr_q),
    .hit_o(lookup_hit), .buf_rdata_o(buf_rdata), .arr_rdata_o(arr_rdata)
  );

  rbc_sa_tracker #(
    .NUM_BANKS(NUM_BANKS), .LEN_W(LW), .T_RFC(T_RFC)
  ) u_sa (
    .clk_i, .rst_ni,
    .start_i(sa_start), .len_i(sa_len), .rfr_i(rfr_start), .busy_o(sa_busy_o)
  );

  rbc_refresh_timer #(
    .INTERVAL(REFRESH_INTERVAL)
  ) u_rfr (
    .clk_i, .rst_ni, .ack_i(rfr_start), .pend_o(rfr_pend)
  );

  always_comb begin
    state_d      = state_q;
    arr_cnt_d    = arr_cnt_q;
    wr_hit       = 1'b0;
    fill         = 1'b0;
    sa_start     = '0;
    sa_len       = LW'(T_CAS);
    rsp_fire     = 1'b0;
    rsp_from_buf = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        if (lookup_hit && !req_write_i) begin
          rsp_fire     = 1'b1;
          rsp_from_buf = 1'b1;
        end else if (lookup_hit && can_sa) begin
          wr_hit   = 1'b1;
          sa_start = NUM_BANKS'(1) << cur_bank;
        end else begin
          state_d = ST_WAIT;
        end
      end
      ST_WAIT: if (can_sa) begin
        sa_start = NUM_BANKS'(1) << cur_bank;
        if (lookup_hit) begin
          wr_hit  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          sa_len    = LW'(T_MISS);
          arr_cnt_d = LW'(T_MISS - 1);
          state_d   = ST_ARRAY;
        end
      end
      ST_ARRAY: begin
        if (arr_cnt_q == '0) begin
          fill     = 1'b1;
          rsp_fire = !wr_q;
          state_d  = ST_IDLE;
        end else begin
          arr_cnt_d = arr_cnt_q - 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      arr_cnt_q    <= '0;
      bank_q       <= '0;
      row_q        <= '0;
      col_q        <= '0;
      wdata_q      <= '0;
      wr_q         <= 1'b0;
      rsp_valid_o  <= 1'b0;
      rsp_data_o   <= '0;
      hit_count_o  <= '0;
      miss_count_o <= '0;
    end else begin
      state_q     <= state_d;
      arr_cnt_q   <= arr_cnt_d;
      rsp_valid_o <= rsp_fire;
      if (rsp_fire) rsp_data_o <= rsp_from_buf ? buf_rdata : arr_rdata;
      if (accept) begin
        bank_q  <= req_bank_i;
        row_q   <= req_row_i;
        col_q   <= req_col_i;
        wdata_q <= req_wdata_i;
        wr_q    <= req_write_i;
        if (lookup_hit) hit_count_o  <= hit_count_o + 1'b1;
        else            miss_count_o <= miss_count_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rbc_fe_checker.sv
module rbc_fe_checker #(
  parameter int NUM_BANKS = 4,
  parameter int CNT_W     = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_valid_i,
  input logic                 req_ready_o,
  input logic                 req_write_i,
  input logic                 rsp_valid_o,
  input logic [NUM_BANKS-1:0] sa_busy_o,
  input logic [CNT_W-1:0]     hit_count_o,
  input logic [CNT_W-1:0]     miss_count_o,
  input logic                 hit_i,
  input logic [NUM_BANKS-1:0] sa_start_i,
  input logic                 rfr_start_i
);
  logic acc;
  assign acc = req_valid_i && req_ready_o;

  AST_HIT_NEXT_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && hit_i && !req_write_i |=> rsp_valid_o); // R2

  AST_MISS_NO_EARLY_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !hit_i |=> !rsp_valid_o); // R4

  AST_WRITE_NO_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && req_write_i |=> !rsp_valid_o); // R8

  AST_SA_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sa_start_i & sa_busy_o) == '0); // R6

  AST_RFR_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rfr_start_i |-> sa_start_i == '0); // R7

  AST_RFR_ALL_BANKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rfr_start_i |=> &sa_busy_o); // R7

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_count_o == $past(hit_count_o) || hit_count_o == $past(hit_count_o) + 1'b1) &&
    (miss_count_o == $past(miss_count_o) || miss_count_o == $past(miss_count_o) + 1'b1)); // R10

  AST_CNT_ONE_SIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_count_o != $past(hit_count_o) && miss_count_o != $past(miss_count_o))); // R10
endmodule

bind rbc_dram_fe rbc_fe_checker #(.NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_write_i (req_write_i),
  .rsp_valid_o (rsp_valid_o),
  .sa_busy_o   (sa_busy_o),
  .hit_count_o (hit_count_o),
  .miss_count_o(miss_count_o),
  .hit_i       (lookup_hit),
  .sa_start_i  (sa_start),
  .rfr_start_i (rfr_start)
);

// File: tb/rbc_dram_fe_tb_top.sv
module rbc_dram_fe_tb_top;
  localparam int NB = 4, ROWS = 8, COLS = 4, DW = 16;
  localparam int T_PRE = 2, T_ACT = 2, T_CAS = 2, T_RFC = 6, RINT = 64;
  localparam int T_MISS = T_PRE + T_ACT + T_CAS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_bank = '0;
  logic [2:0] req_row = '0;
  logic [1:0] req_col = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [DW-1:0] rsp_data;
  logic [NB-1:0] sa_busy;
  logic [15:0] hit_cnt, miss_cnt;

  always #2ns clk = ~clk;

  rbc_dram_fe #(
    .NUM_BANKS(NB), .ROWS(ROWS), .COLS(COLS), .DATA_W(DW),
    .T_PRE(T_PRE), .T_ACT(T_ACT), .T_CAS(T_CAS), .T_RFC(T_RFC),
    .REFRESH_INTERVAL(RINT), .CNT_W(16)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_bank_i(req_bank), .req_row_i(req_row), .req_col_i(req_col),
    .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .sa_busy_o(sa_busy),
    .hit_count_o(hit_cnt), .miss_count_o(miss_cnt)
  );

  int checks = 0, errors = 0, cyc = 0;
  int exp_hit = 0, exp_miss = 0;
  logic [DW-1:0] mem [NB][ROWS][COLS];
  int  brow [NB];
  bit  bvld [NB];
  logic [DW-1:0] exp_q [$];

  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R8 unexpected response", rsp_data, 0);
      else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        check(rsp_data == e, "R8 response data/order", rsp_data, e);
      end
    end
  end

  task automatic drive_req(input bit wr, input int b, input int r, input int c, input logic [DW-1:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr;
    req_bank = 2'(b); req_row = 3'(r); req_col = 2'(c); req_wdata = d;
    if (bvld[b] && brow[b] == r) exp_hit++; else exp_miss++;
    if (wr) mem[b][r][c] = d;
    else    exp_q.push_back(mem[b][r][c]);
    brow[b] = r; bvld[b] = 1'b1;
  endtask

  task automatic write_req(input int b, input int r, input int c, input logic [DW-1:0] d);
    drive_req(1'b1, b, r, c, d);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // k = number of falling edges after the accepting edge until rsp_valid
  task automatic finish_read(output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
      if (k == 1) req_valid = 1'b0;
    end while (!rsp_valid && k < 40);
  endtask

  task automatic read_req(input int b, input int r, input int c, output int k);
    drive_req(1'b0, b, r, c, '0);
    finish_read(k);
  endtask

  task automatic wait_all_busy_rise();
    bit prev;
    prev = 1'b1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (&sa_busy && !prev) return;
      prev = &sa_busy;
    end
    check(1'b0, "R7 refresh never seen", 0, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int k, t0, n, m0;
    for (int b = 0; b < NB; b++) begin
      brow[b] = 0; bvld[b] = 1'b0;
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++) mem[b][r][c] = '0;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1, "R1 ready", req_ready, 1);
    check(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
    check(sa_busy == '0, "R1 sa_busy", sa_busy, 0);
    check(hit_cnt == 0 && miss_cnt == 0, "R1 counters", {hit_cnt, miss_cnt}, 0);
    rst_n = 1'b1;

    // R4 miss latency, bank idle, no refresh pending
    read_req(3, 0, 0, k);
    check(k == T_MISS + 2, "R4 miss latency", k, T_MISS + 2);

    // R11 write miss opens row; R2 hit served from buffer, no SA use
    write_req(0, 1, 2, 16'hA5A5);
    read_req(0, 1, 2, k);
    check(k == 1, "R2/R11 hit latency after write miss", k, 1);
    check(sa_busy[0] == 1'b0, "R2 hit leaves SA idle", sa_busy[0], 0);

    // R5 write hit, then R3 read hit while SA held by the write
    write_req(0, 1, 3, 16'h1234);
    drive_req(1'b0, 0, 1, 3, '0);
    check(sa_busy[0] == 1'b1, "R3 SA busy during read hit", sa_busy[0], 1);
    finish_read(k);
    check(k == 1, "R3/R5 hit latency with SA busy", k, 1);

    // R6 writes serialised
    write_req(1, 2, 3, 16'h0033);
    write_req(1, 2, 0, 16'h0011);
    write_req(1, 2, 1, 16'h0022);
    check(req_ready == 1'b0, "R6 second write held", req_ready, 0);
    read_req(1, 2, 0, k);
    check(k == 1, "R5 hit after serialised writes", k, 1);
    read_req(1, 2, 1, k);
    write_req(2, 5, 1, 16'h5555);

    // R7 refresh length and period
    wait_all_busy_rise();
    t0 = cyc; n = 1;
    while (&sa_busy) begin @(negedge clk); if (&sa_busy) n++; end
    check(n == T_RFC, "R7 refresh length", n, T_RFC);
    wait_all_busy_rise();
    check(cyc - t0 == RINT, "R7 refresh period", cyc - t0, RINT);

    // R3 read hit during refresh
    wait_all_busy_rise();
    drive_req(1'b0, 1, 2, 0, '0);
    check(&sa_busy, "R3 SA busy by refresh during hit", sa_busy, 4'hF);
    finish_read(k);
    check(k == 1, "R3 hit latency during refresh", k, 1);

    // R9 alternating rows on one bank always miss
    while (|sa_busy) @(negedge clk);
    m0 = exp_miss;
    for (int i = 0; i < 4; i++) begin
      read_req(2, (i % 2 == 0) ? 6 : 5, 1, k);
      check(k == T_MISS + 2, "R9 alternating row miss latency", k, T_MISS + 2);
    end
    check(int'(miss_cnt) - m0 == 4, "R9 miss count delta", int'(miss_cnt) - m0, 4);
    read_req(2, 5, 1, k);
    check(k == 1, "R9 same row again hits", k, 1);

    repeat (4) @(negedge clk);
    check(hit_cnt == 16'(exp_hit), "R10 hit counter", hit_cnt, exp_hit);
    check(miss_cnt == 16'(exp_miss), "R10 miss counter", miss_cnt, exp_miss);
    check(exp_q.size() == 0, "R8 all responses returned", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule